// File: doc/BRIEF.md
# Video Line FIFO with Programmable Level Flags

This block is one channel of a 12-bit video line store used as a first-in first-out queue. Words are written on a write clock and read on a read clock. The two clocks may be the same net or fully independent. Each pointer crosses into the other clock domain as a Gray code through a two-flop synchronizer. An active-low reset-write input rewinds the write side and an active-low reset-read input rewinds the read side. At power-up the read side holds no defined position, so a reset-read must be applied before the first read.

Two level thresholds set the almost-empty and almost-full flags. Software loads them through the ordinary data input. While the load strobe is low, a single select bit steers the word on the input into one of the two thresholds instead of into the queue. The read data sits in an output register. An active-low output enable either drives that register onto the output pins or releases them to high impedance. To change how the channel is used, either let enough cycles pass to drain the storage, or pull both resets low together.

Top module: `vlf_line_fifo`

## Requirements
- R1: While both resets are low, and after they are released, `empty` is 1, `full` is 0, and the output register holds zero. Both thresholds return to their default parameter values.
- R2: On a rising `wr_clk` edge with `wr_en`=1, `ld_n`=1 and `full`=0, the word on `din` is stored and the write pointer advances by one.
- R3: On a rising `rd_clk` edge with `rd_en`=1 and `empty`=0, the oldest stored word, in write order, is loaded into the output register and the read pointer advances by one. In any other cycle the output register holds its value.
- R4: With `oe_n`=1 every bit of `dout` is high impedance. With `oe_n`=0, `dout` shows the output register.
- R5: On a rising `wr_clk` edge with `ld_n`=0, `din` is written into the almost-empty threshold when `thr_sel`=0, or into the almost-full threshold when `thr_sel`=1. `din[0]` maps to the threshold LSB. Nothing is pushed into the queue, even if `wr_en`=1.
- R6: `almost_empty` is 1 when the read side's view of the occupancy is less than or equal to the almost-empty threshold.
- R7: `almost_full` is 1 when the write side's view of the free space is less than or equal to the almost-full threshold.
- R8: `full` is 1 when 2^ADDR_W words are held. A write while full is ignored, and neither the pointer nor the stored data changes.
- R9: A read while `empty` is 1 is ignored, and neither the read pointer nor the output register changes.
- R10: Driving both resets low together discards all stored words. Data written afterwards is read back correctly.
- R11: Each Gray-coded pointer changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Reset-write, active low; rewinds write pointer, restores thresholds |
| wr_en | input | 1 | Push request |
| ld_n | input | 1 | Threshold load strobe, active low |
| thr_sel | input | 1 | Threshold select: 0 almost-empty, 1 almost-full |
| din | input | DATA_W | Data or threshold value |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Reset-read, active low; rewinds read pointer, clears output register |
| rd_en | input | 1 | Pop request |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Tri-stated output register |
| empty | output | 1 | No word visible to the read side |
| almost_empty | output | 1 | Occupancy at or below its threshold |
| full | output | 1 | No room visible to the write side |
| almost_full | output | 1 | Free space at or below its threshold |

## Verification
The checker tests several rules on every clock:
- pointer advance on an accepted push or pop
- pointer stillness on a blocked push, a threshold load or a read at empty
- single-bit Gray steps
- `full` implies `almost_full`, and `empty` implies `almost_empty`

Only the directed scenarios can show the following:
- data order across wrap-around
- the exact occupancy at which each level flag switches
- the high-impedance output
- the effect of the reset that flushes both sides

// File: rtl/vlf_pkg.sv
package vlf_pkg;

    typedef enum logic {
        THR_LOW  = 1'b0,
        THR_HIGH = 1'b1
    } thr_sel_e;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/vlf_sync.sv
module vlf_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/vlf_mem.sv
module vlf_mem #(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 12,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/vlf_wr_ctrl.sv
module vlf_wr_ctrl
    import vlf_pkg::*;
#(
    parameter int              DATA_W  = 12,
    parameter int              ADDR_W  = 12,
    parameter logic [DATA_W-1:0] AE_INIT = 12'd8,
    parameter logic [DATA_W-1:0] AF_INIT = 12'd8,
    localparam int             PW      = ADDR_W + 1,
    localparam int             CW      = (PW > DATA_W) ? PW : DATA_W
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic              ld_n,
    input  logic              thr_sel,
    input  logic [DATA_W-1:0] din,
    input  logic [PW-1:0]     rgray_sync,
    output logic [PW-1:0]     wbin,
    output logic [PW-1:0]     wgray,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic              full,
    output logic              almost_full,
    output logic [DATA_W-1:0] ae_thr
);
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

    typedef struct packed {
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        logic [DATA_W-1:0] ae;
        logic [DATA_W-1:0] af;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [PW-1:0] rbin_s, used, free;
    logic          push;

    always_comb begin
        rbin_s      = PW'(from_gray(32'(rgray_sync)));
        used        = st_q.bin - rbin_s;
        free        = DEPTH_P - used;
        full        = (used == DEPTH_P);
        almost_full = (CW'(free) <= CW'(st_q.af));
        push        = wr_en && ld_n && !full;

        st_d = st_q;
        if (!ld_n) begin
            if (thr_sel_e'(thr_sel) == THR_HIGH) st_d.af = din;
            else                                 st_d.ae = din;
        end
        if (push) begin
            st_d.bin  = st_q.bin + 1'b1;
            st_d.gray = PW'(to_gray(32'(st_d.bin)));
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            st_q.bin  <= '0;
            st_q.gray <= '0;
            st_q.ae   <= AE_INIT;
            st_q.af   <= AF_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign wbin   = st_q.bin;
    assign wgray  = st_q.gray;
    assign we     = push;
    assign waddr  = st_q.bin[ADDR_W-1:0];
    assign ae_thr = st_q.ae;
endmodule

// File: rtl/vlf_rd_ctrl.sv
module vlf_rd_ctrl
    import vlf_pkg::*;
#(
    parameter int  DATA_W = 12,
    parameter int  ADDR_W = 12,
    localparam int PW     = ADDR_W + 1,
    localparam int CW     = (PW > DATA_W) ? PW : DATA_W
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [PW-1:0]     wgray_sync,
    input  logic [DATA_W-1:0] ae_thr_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [PW-1:0]     rbin,
    output logic [PW-1:0]     rgray,
    output logic [DATA_W-1:0] dout_q,
    output logic              empty,
    output logic              almost_empty
);
    typedef struct packed {
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [PW-1:0] wbin_s, used;
    logic          pop;

    always_comb begin
        wbin_s       = PW'(from_gray(32'(wgray_sync)));
        used         = wbin_s - st_q.bin;
        empty        = (used == '0);
        almost_empty = (CW'(used) <= CW'(ae_thr_sync));
        pop          = rd_en && !empty;

        st_d = st_q;
        if (pop) begin
            st_d.data = mem_rdata;
            st_d.bin  = st_q.bin + 1'b1;
            st_d.gray = PW'(to_gray(32'(st_d.bin)));
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) st_q <= '0;
        else           st_q <= st_d;
    end

    assign raddr  = st_q.bin[ADDR_W-1:0];
    assign rbin   = st_q.bin;
    assign rgray  = st_q.gray;
    assign dout_q = st_q.data;
endmodule

// File: rtl/vlf_line_fifo.sv
module vlf_line_fifo #(
    parameter int              DATA_W  = 12,
    parameter int              ADDR_W  = 12,
    parameter logic [DATA_W-1:0] AE_INIT = 12'd8,
    parameter logic [DATA_W-1:0] AF_INIT = 12'd8
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic              ld_n,
    input  logic              thr_sel,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              almost_empty,
    output logic              full,
    output logic              almost_full
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wbin, wgray, rbin, rgray, wgray_sync, rgray_sync;
    logic [DATA_W-1:0] ae_thr, ae_thr_sync, mem_rdata, dout_q;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              we;

    vlf_wr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_INIT(AE_INIT), .AF_INIT(AF_INIT)) u_wr (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .ld_n(ld_n),
        .thr_sel(thr_sel), .din(din), .rgray_sync(rgray_sync),
        .wbin(wbin), .wgray(wgray), .we(we), .waddr(waddr),
        .full(full), .almost_full(almost_full), .ae_thr(ae_thr)
    );

    vlf_sync #(.W(PW)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_sync)
    );

    vlf_sync #(.W(PW)) u_sync_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_sync)
    );

    vlf_sync #(.W(DATA_W), .RST_VAL(AE_INIT)) u_sync_thr (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(ae_thr), .q(ae_thr_sync)
    );

    vlf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(mem_rdata)
    );

    vlf_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
        .wgray_sync(wgray_sync), .ae_thr_sync(ae_thr_sync), .mem_rdata(mem_rdata),
        .raddr(raddr), .rbin(rbin), .rgray(rgray), .dout_q(dout_q),
        .empty(empty), .almost_empty(almost_empty)
    );

    assign dout = oe_n ? {DATA_W{1'bz}} : dout_q;
endmodule

// File: rtl/vlf_line_fifo_chk.sv
module vlf_line_fifo_chk #(
    parameter int PW     = 13,
    parameter int DATA_W = 12
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              wr_rst_n,
    input logic              rd_rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              ld_n,
    input logic              full,
    input logic              empty,
    input logic              almost_full,
    input logic              almost_empty,
    input logic [PW-1:0]     wbin,
    input logic [PW-1:0]     rbin,
    input logic [PW-1:0]     wgray,
    input logic [PW-1:0]     rgray,
    input logic [DATA_W-1:0] dout_q
);
    assert_push_step_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && ld_n && !full) |=> (wbin == PW'($past(wbin) + 1'b1)));

    assert_load_no_push_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!ld_n) |=> $stable(wbin));

    assert_no_overflow_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (full && wr_en) |=> $stable(wbin));

    assert_full_in_af_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        full |-> almost_full);

    assert_wgray_step_R11: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_pop_step_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && !empty) |=> (rbin == PW'($past(rbin) + 1'b1)));

    assert_no_underflow_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && empty) |=> ($stable(rbin) && $stable(dout_q)));

    assert_empty_in_ae_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        empty |-> almost_empty);

    assert_rgray_step_R11: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind vlf_line_fifo vlf_line_fifo_chk #(.PW(ADDR_W + 1), .DATA_W(DATA_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .ld_n(ld_n), .full(full), .empty(empty),
    .almost_full(almost_full), .almost_empty(almost_empty),
    .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray), .dout_q(dout_q)
);

// File: tb/sim_vlf_line_fifo.sv
`timescale 1ns/1ps
module sim_vlf_line_fifo;
    localparam int DW = 12;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, ld_n = 1'b1, thr_sel = 1'b0, oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    wire  [DW-1:0] dout;
    wire empty, almost_empty, full, almost_full;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vlf_line_fifo #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .wr_clk(clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .ld_n(ld_n),
        .thr_sel(thr_sel), .din(din), .rd_clk(clk), .rd_rst_n(rd_rst_n),
        .rd_en(rd_en), .oe_n(oe_n), .dout(dout), .empty(empty),
        .almost_empty(almost_empty), .full(full), .almost_full(almost_full)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge clk); din = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [DW-1:0] v);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk(req, dout, v);
    endtask

    task automatic load_thr(input logic sel, input logic [DW-1:0] v);
        @(negedge clk); ld_n = 1'b0; thr_sel = sel; din = v; wr_en = 1'b1;
        @(negedge clk); ld_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic t_reset();
        settle();
        chk("R1 empty", {11'd0, empty}, 12'd1);
        chk("R1 full", {11'd0, full}, 12'd0);
        chk("R1 dout", dout, 12'h000);
        chk("R1 ae default", {11'd0, almost_empty}, 12'd1);
        chk("R1 af default", {11'd0, almost_full}, 12'd0);
    endtask

    task automatic t_order();
        for (int i = 0; i < 5; i++) push(12'hA00 + 12'(i));
        settle();
        chk("R2 not empty", {11'd0, empty}, 12'd0);
        for (int i = 0; i < 5; i++) pop_expect("R3 order", 12'hA00 + 12'(i));
        settle();
        chk("R3 drained", {11'd0, empty}, 12'd1);
        repeat (2) @(negedge clk);
        chk("R3 dout holds", dout, 12'hA04);
    endtask

    task automatic t_oe();
        @(negedge clk); oe_n = 1'b1;
        @(negedge clk);
        chk("R4 high-Z", dout, 12'hzzz);
        oe_n = 1'b0;
        @(negedge clk);
        chk("R4 driven", dout, 12'hA04);
    endtask

    task automatic t_load();
        load_thr(1'b0, 12'd3);
        load_thr(1'b1, 12'd2);
        settle();
        chk("R5 load no push", {11'd0, empty}, 12'd1);
    endtask

    task automatic t_levels();
        for (int i = 0; i < 3; i++) push(12'h100 + 12'(i));
        settle();
        chk("R6 ae at 3", {11'd0, almost_empty}, 12'd1);
        push(12'h103);
        settle();
        chk("R6 ae off at 4", {11'd0, almost_empty}, 12'd0);
        for (int i = 4; i < 13; i++) push(12'h100 + 12'(i));
        settle();
        chk("R7 af off at free 3", {11'd0, almost_full}, 12'd0);
        push(12'h10D);
        settle();
        chk("R7 af on at free 2", {11'd0, almost_full}, 12'd1);
        push(12'h10E);
        push(12'h10F);
        settle();
        chk("R8 full", {11'd0, full}, 12'd1);
    endtask

    task automatic t_overflow();
        push(12'hFFF);
        settle();
        for (int i = 0; i < DEPTH; i++) pop_expect("R8 no overwrite", 12'h100 + 12'(i));
        settle();
        chk("R8 extra dropped", {11'd0, empty}, 12'd1);
    endtask

    task automatic t_underflow();
        pop_expect("R9 dout kept", 12'h10F);
        push(12'h2AA);
        settle();
        pop_expect("R9 pointer kept", 12'h2AA);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 3; i++) push(12'h500 + 12'(i));
        settle();
        @(negedge clk); wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        settle();
        chk("R10 empty", {11'd0, empty}, 12'd1);
        chk("R10 dout cleared", dout, 12'h000);
        push(12'h3C3);
        settle();
        pop_expect("R10 fresh data", 12'h3C3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        t_reset();
        t_order();
        t_oe();
        t_load();
        t_levels();
        t_overflow();
        t_underflow();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule